// File: doc/BRIEF.md
# Bidirectional Token Column Loader

This block fills a bank of column registers with 6-bit gray-level words. A single start bit enters through one of two token pins. It then walks along the columns, and on each shift-clock edge exactly one armed column takes the word on the data bus. The walk can run upward from the lowest column or downward from the highest. The bank can use every column, or it can skip four columns at each end so that a narrower panel is served. Each load word lags the start bit by two shift-clock edges. When the last active column has been written, the token pin that is not being used as an input pulses for one clock. This pulse starts the next device in a cascade.

Internally the token moves through a chain of column pairs. The pair chain advances on every second edge, and a phase bit picks which column of the armed pair is written. This halves the token flops and their switching. A level-sensitive strobe controls the output bank. While the strobe is low the output bank follows the temporary bank. While it is high the output bank holds. The data input is a valid/ready stream with no back-pressure. Ready is high in each cycle whose closing edge writes an armed column. A word offered while ready is low is dropped. A word with valid low on a ready cycle leaves that column unchanged, and the token still moves on.

Top module: `cl_loader`

## Requirements
- R1: While rst_n is low, and on release, col_out is all zero, din_ready is low, and tka_o and tkb_o are low.
- R2: With dir_fwd=1, tka is the token input (tka_oe=0) and tkb is driven (tkb_oe=1). With dir_fwd=0 the roles swap.
- R3: The token is sampled on a rising clk edge (edge 0). The k-th active column (k from 0) samples din at edge 2+k. din_ready is high during the cycle that ends at each such edge.
- R4: With dir_fwd=1 and full_sel=1, columns load in ascending order 0 to NCH-1. Column c occupies col_out[6c+5:6c].
- R5: With dir_fwd=0 and full_sel=1, columns load in descending order NCH-1 down to 0.
- R6: With full_sel=0, only columns TRIM to NCH-1-TRIM load. The walk starts at column TRIM (dir_fwd=1) or NCH-1-TRIM (dir_fwd=0). The edge columns keep their values.
- R7: If din_valid is low at a column's sampling edge, that column keeps its previous word and the walk still advances.
- R8: The driven token pin is high for exactly one cycle, starting at the edge that writes the last active column. It is low otherwise.
- R9: A token presented while a walk is in progress is ignored. No second walk starts.
- R10: With lat low, col_out shows the temporary bank as updated by the latest edge. With lat high at an edge, col_out does not change.
- R11: At most one column is written per clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge |
| rst_n | input | 1 | Active-low master reset |
| dir_fwd | input | 1 | 1: ascending walk, token enters on tka; 0: descending, enters on tkb |
| full_sel | input | 1 | 1: all NCH columns; 0: skip TRIM columns at each end |
| din | input | 6 | Gray-level word |
| din_valid | input | 1 | Word on din is to be written |
| din_ready | output | 1 | A column will sample din at the next edge |
| lat | input | 1 | Output bank strobe: low follows, high holds |
| tka_i | input | 1 | Token pin A, input value |
| tka_o | output | 1 | Token pin A, driven value |
| tka_oe | output | 1 | Token pin A, drive enable |
| tkb_i | input | 1 | Token pin B, input value |
| tkb_o | output | 1 | Token pin B, driven value |
| tkb_oe | output | 1 | Token pin B, drive enable |
| col_out | output | NCH*6 | Output bank, column c at bits 6c+5:6c |

## Verification
The assertions assume that dir_fwd and full_sel stay unchanged from the token edge until the cascade pulse. They also assume that lat changes only away from a rising clk edge, so the hold check compares stable values. The bench changes direction and width only between walks. It drives every input on the falling edge, presents the token for a single cycle, and moves lat between edges. Repeat tokens arrive only in the middle of a walk, which exercises the ignore rule.

// File: rtl/cl_pkg.sv
package cl_pkg;

  typedef struct packed {
    logic        hit;   // column lies in the active window
    logic        odd;   // second column of its pair
    logic [15:0] pair;  // pair index along the walk
  } slot_t;

  // Position of a physical column along the walk for the chosen direction and width
  function automatic slot_t map_slot(input int ch, input logic fwd, input logic full,
                                     input int nch, input int trim);
    slot_t s;
    int lo;
    int hi;
    int m;
    lo     = full ? 0 : trim;
    hi     = full ? nch - 1 : nch - 1 - trim;
    m      = fwd ? ch - lo : hi - ch;
    s.hit  = (ch >= lo) && (ch <= hi);
    s.odd  = m[0];
    s.pair = m[16:1];
    return s;
  endfunction

endpackage

// File: rtl/cl_token_walk.sv
module cl_token_walk #(
  parameter int NP   = 100,
  parameter int TRIM = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tok_in,
  input  logic          full,
  output logic [NP-1:0] arm,
  output logic          phase,
  output logic          casc
);
  localparam int LAST_FULL = NP - 1;
  localparam int LAST_RED  = NP - TRIM - 1;

  logic start_q;
  logic busy;
  logic last_pair;

  assign busy      = start_q || (|arm);
  assign last_pair = full ? arm[LAST_FULL] : arm[LAST_RED];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      arm     <= '0;
      phase   <= 1'b0;
      casc    <= 1'b0;
    end else begin
      start_q <= tok_in && !busy;
      casc    <= 1'b0;
      if (start_q) begin
        arm   <= NP'(1);
        phase <= 1'b0;
      end else if (|arm) begin
        if (phase) begin
          if (last_pair) begin
            arm  <= '0;
            casc <= 1'b1;
          end else begin
            arm <= arm << 1;
          end
        end
        phase <= ~phase;
      end
    end
  end

  // R11: the pair chain never holds more than one token
  assert_single_token_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(arm));

  // R8: the cascade pulse lasts a single cycle
  assert_casc_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    casc |=> !casc);

endmodule

// File: rtl/cl_column_bank.sv
module cl_column_bank
  import cl_pkg::*;
#(
  parameter int NCH  = 200,
  parameter int DW   = 6,
  parameter int TRIM = 4,
  parameter int NP   = NCH / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fwd,
  input  logic              full,
  input  logic [NP-1:0]     arm,
  input  logic              phase,
  input  logic [DW-1:0]     din,
  input  logic              din_valid,
  input  logic              lat,
  output logic [NCH*DW-1:0] col_out
);
  localparam int PW = (NP > 1) ? $clog2(NP) : 1;

  logic [NCH-1:0] we;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_col
    slot_t         s;
    logic [DW-1:0] tmp_q;
    logic [DW-1:0] tmp_nx;
    logic [DW-1:0] hold_q;

    assign s      = map_slot(ch, fwd, full, NCH, TRIM);
    assign we[ch] = s.hit && arm[s.pair[PW-1:0]] && (phase == s.odd) && din_valid;
    assign tmp_nx = we[ch] ? din : tmp_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tmp_q <= '0;
      else        tmp_q <= tmp_nx;
    end

    // the hold copy tracks the post-edge temporary value while the strobe is low
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    hold_q <= '0;
      else if (!lat) hold_q <= tmp_nx;
    end

    assign col_out[ch*DW +: DW] = lat ? hold_q : tmp_q;
  end

  // R11: one column captures per edge at most
  assert_one_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we));

endmodule

// File: rtl/cl_loader.sv
module cl_loader #(
  parameter int NCH  = 200,
  parameter int DW   = 6,
  parameter int TRIM = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_fwd,
  input  logic              full_sel,
  input  logic [DW-1:0]     din,
  input  logic              din_valid,
  output logic              din_ready,
  input  logic              lat,
  input  logic              tka_i,
  output logic              tka_o,
  output logic              tka_oe,
  input  logic              tkb_i,
  output logic              tkb_o,
  output logic              tkb_oe,
  output logic [NCH*DW-1:0] col_out
);
  localparam int NP = NCH / 2;

  logic [NP-1:0] arm;
  logic          phase;
  logic          casc;
  logic          tok_in;

  assign tok_in    = dir_fwd ? tka_i : tkb_i;
  assign tka_oe    = !dir_fwd;
  assign tkb_oe    = dir_fwd;
  assign tka_o     = !dir_fwd && casc;
  assign tkb_o     = dir_fwd && casc;
  assign din_ready = |arm;

  cl_token_walk #(.NP(NP), .TRIM(TRIM)) u_walk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tok_in (tok_in),
    .full   (full_sel),
    .arm    (arm),
    .phase  (phase),
    .casc   (casc)
  );

  cl_column_bank #(.NCH(NCH), .DW(DW), .TRIM(TRIM), .NP(NP)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .fwd       (dir_fwd),
    .full      (full_sel),
    .arm       (arm),
    .phase     (phase),
    .din       (din),
    .din_valid (din_valid),
    .lat       (lat),
    .col_out   (col_out)
  );

  // R8: the walk is finished when the cascade pulse appears
  assert_casc_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tka_o || tkb_o) |-> !din_ready);

  // R10: a strobe held high across an edge freezes the output bank
  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lat && $past(lat)) |-> $stable(col_out));

endmodule

// File: tb/tb_cl_loader.sv
module tb_cl_loader;
  localparam int NCH  = 200;
  localparam int DW   = 6;
  localparam int TRIM = 4;
  localparam int NV   = 8;

  // fields: dir, full, lat, retok, skip[3:0], seed[5:0]
  localparam logic [13:0] VECS [NV] = '{
    {1'b1, 1'b1, 1'b0, 1'b0, 4'd0, 6'd5},
    {1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 6'd17},
    {1'b1, 1'b0, 1'b0, 1'b1, 4'd0, 6'd40},
    {1'b0, 1'b0, 1'b0, 1'b0, 4'd3, 6'd9},
    {1'b1, 1'b1, 1'b1, 1'b1, 4'd5, 6'd63},
    {1'b0, 1'b1, 1'b0, 1'b0, 4'd2, 6'd0},
    {1'b1, 1'b0, 1'b1, 1'b0, 4'd0, 6'd33},
    {1'b0, 1'b0, 1'b0, 1'b1, 4'd0, 6'd22}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              dir_fwd = 1'b1;
  logic              full_sel = 1'b1;
  logic [DW-1:0]     din = '0;
  logic              din_valid = 1'b0;
  logic              din_ready;
  logic              lat = 1'b0;
  logic              tka_i = 1'b0;
  logic              tka_o;
  logic              tka_oe;
  logic              tkb_i = 1'b0;
  logic              tkb_o;
  logic              tkb_oe;
  logic [NCH*DW-1:0] col_out;

  logic [DW-1:0] exp_q  [NCH];
  logic [DW-1:0] snap_q [NCH];
  int n_chk = 0;
  int n_bad = 0;

  cl_loader #(.NCH(NCH), .DW(DW), .TRIM(TRIM)) dut (
    .clk(clk), .rst_n(rst_n), .dir_fwd(dir_fwd), .full_sel(full_sel),
    .din(din), .din_valid(din_valid), .din_ready(din_ready), .lat(lat),
    .tka_i(tka_i), .tka_o(tka_o), .tka_oe(tka_oe),
    .tkb_i(tkb_i), .tkb_o(tkb_o), .tkb_oe(tkb_oe), .col_out(col_out)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic bank_cmp(input string req, input bit use_snap);
    int bad_ch = -1;
    int a = 0;
    int e = 0;
    for (int ch = 0; ch < NCH; ch++) begin
      logic [DW-1:0] want;
      want = use_snap ? snap_q[ch] : exp_q[ch];
      if (bad_ch < 0 && col_out[ch*DW +: DW] !== want) begin
        bad_ch = ch;
        a = int'(col_out[ch*DW +: DW]);
        e = int'(want);
      end
    end
    chk(bad_ch < 0, req, $sformatf("bank column %0d", bad_ch), a, e);
  endtask

  task automatic run_load(input logic f, input logic fu, input bit lat_hi,
                          input bit retok, input int skip, input int seed);
    int cnt;
    int lo;
    int hi;
    string rq;
    cnt = fu ? NCH : NCH - 2*TRIM;
    lo  = fu ? 0 : TRIM;
    hi  = fu ? NCH - 1 : NCH - 1 - TRIM;
    rq  = (skip != 0) ? "R7" : (!fu ? "R6" : (f ? "R4" : "R5"));
    @(negedge clk);
    dir_fwd  = f;
    full_sel = fu;
    lat      = lat_hi;
    for (int ch = 0; ch < NCH; ch++) snap_q[ch] = exp_q[ch];
    @(negedge clk);
    chk(tka_oe == !f && tkb_oe == f, "R2", "token pin roles",
        int'({tka_oe, tkb_oe}), int'({!f, f}));
    if (f) tka_i = 1'b1; else tkb_i = 1'b1;
    @(negedge clk);
    tka_i = 1'b0;
    tkb_i = 1'b0;
    for (int k = 0; k < cnt; k++) begin
      int ch;
      logic [DW-1:0] w;
      bit v;
      @(negedge clk);
      chk(din_ready == 1'b1, "R3", $sformatf("ready slot %0d", k), int'(din_ready), 1);
      if (k == 5 && !lat_hi) begin
        int pc;
        pc = f ? lo + 4 : hi - 4;
        chk(col_out[pc*DW +: DW] == exp_q[pc], "R10", "transparent column",
            int'(col_out[pc*DW +: DW]), int'(exp_q[pc]));
      end
      if (k == 7) chk((tka_o | tkb_o) == 1'b0, "R8", "no cascade mid walk",
                      int'(tka_o | tkb_o), 0);
      w  = DW'(seed + 7*k + (k >> 3));
      v  = !(skip != 0 && (k % skip) == 0);
      ch = f ? lo + k : hi - k;
      din       = w;
      din_valid = v;
      if (v) exp_q[ch] = w;
      if (retok && k == 3) begin
        if (f) tka_i = 1'b1; else tkb_i = 1'b1;
      end
      if (retok && k == 4) begin
        tka_i = 1'b0;
        tkb_i = 1'b0;
      end
    end
    @(negedge clk);
    din_valid = 1'b0;
    chk((f ? tkb_o : tka_o) == 1'b1, "R8", "cascade pulse", int'(f ? tkb_o : tka_o), 1);
    chk((f ? tka_o : tkb_o) == 1'b0, "R2", "input pin not driven", int'(f ? tka_o : tkb_o), 0);
    chk(din_ready == 1'b0, "R3", "ready after last", int'(din_ready), 0);
    @(negedge clk);
    chk((f ? tkb_o : tka_o) == 1'b0, "R8", "cascade width", int'(f ? tkb_o : tka_o), 0);
    @(negedge clk);
    chk(din_ready == 1'b0, "R9", "no second walk", int'(din_ready), 0);
    if (lat_hi) begin
      bank_cmp("R10", 1'b1);
      @(negedge clk);
      lat = 1'b0;
      #1;
      bank_cmp(rq, 1'b0);
    end else begin
      bank_cmp(rq, 1'b0);
    end
  endtask

  task automatic reset_check(input string what);
    chk(col_out == '0, "R1", {what, " bank"}, 0, 0);
    chk(din_ready == 1'b0 && tka_o == 1'b0 && tkb_o == 1'b0, "R1", {what, " outputs"},
        int'({din_ready, tka_o, tkb_o}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int ch = 0; ch < NCH; ch++) exp_q[ch] = '0;
    repeat (3) @(negedge clk);
    reset_check("in reset");
    rst_n = 1'b1;
    @(negedge clk);
    reset_check("after release");

    for (int i = 0; i < NV; i++) begin
      logic [13:0] v;
      v = VECS[i];
      run_load(v[13], v[12], v[11], v[10], int'(v[9:6]), int'(v[5:0]));
    end

    // R10: raise the strobe mid-cycle, then a partial load must not reach the outputs
    @(negedge clk);
    lat = 1'b1;
    for (int ch = 0; ch < NCH; ch++) snap_q[ch] = exp_q[ch];
    dir_fwd = 1'b1;
    full_sel = 1'b1;
    tka_i = 1'b1;
    @(negedge clk);
    tka_i = 1'b0;
    @(negedge clk);
    din = 6'd44;
    din_valid = 1'b1;
    @(negedge clk);
    din_valid = 1'b0;
    exp_q[0] = 6'd44;
    bank_cmp("R10", 1'b1);

    // R1: reset in the middle of a walk clears everything
    rst_n = 1'b0;
    @(negedge clk);
    reset_check("mid-walk reset");
    rst_n = 1'b1;
    lat = 1'b0;
    repeat (3) @(negedge clk);
    reset_check("idle after reset");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule